// File: doc/BRIEF.md
# I2C Port Expander, Eight Pins

This block is a slave on a two-wire serial bus. It gives a host control of eight general-purpose pins through four byte-wide registers. The host addresses the slave and then sends a command byte. That byte is kept as a pointer, and every data byte that follows in the same transaction, or in a later read, goes to the register it names.

The registers are:
- a live view of the pins, which can only be read;
- the levels the pins drive;
- a per-bit inversion mask, applied to the pin view when it is read;
- a direction mask.

SCL and SDA are oversampled by the system clock after a synchroniser. START and STOP are found as SDA edges while SCL is high. The pad is modelled as separate input, output and output-enable vectors, and the SDA pull-down is a single enable.

Top module: `i2c_port_expander`

## Requirements
- R1: After reset the drive register is 0xFF, the inversion mask is 0x00 and the direction mask is 0xFF, so every pin output-enable is low.
- R2: The slave acknowledges an address byte whose upper seven bits equal the parameter SLV_ADDR (bit 0 = 1 means read). For any other address it leaves SDA released and ignores the rest of that transaction up to the next START or STOP.
- R3: The first byte after a write address is taken as the command pointer and acknowledged. Pointer values are: 0x00 pin view, 0x01 drive, 0x02 inversion, 0x03 direction.
- R4: Data bytes written under pointers 0x01, 0x02 or 0x03 are acknowledged and stored, and reading them back returns the stored value.
- R5: Direction bit n = 0 enables pin n's driver with drive bit n. Direction bit n = 1 disables that driver. Drive levels are never inverted.
- R6: Reading pointer 0x00 returns the synchronised level of every pin, including pins that drive, with each bit XORed with its inversion bit.
- R7: A write under pointer 0x00 is acknowledged and has no effect on any register or pin.
- R8: A read byte is sent MSB first, with SDA changed only while SCL is low. A master ACK brings the next byte. A master NACK makes the slave release SDA until the next START or STOP.
- R9: There is no auto-increment. Several data bytes in one write all land in the same register, so the last one remains. A read after a repeated START returns the register named by the last command byte.
- R10: Pointer values above 0x03 are acknowledged. Writes under them change nothing, and reads under them return 0x00.
- R11: A STOP returns the slave to idle with SDA released. A new transaction after it, including a read with no new command byte, works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pin_i | input | 8 | Pad input levels |
| pin_o | output | 8 | Pad output levels |
| pin_oe_o | output | 8 | Pad driver enables |

## Verification
A drive-register write and the pin sampling behind the pin-view register can meet on the same pins: a pin set as output feeds its own driven level back into the pin view. The bench models the pad as driven level where enabled and an external pattern elsewhere. It then writes the drive, direction and inversion registers and reads pointer 0x00. Each returned byte is judged against the mixed pad value XORed with the mask, which the bench computes from its own register model.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam int BYTE_W = 8;

  localparam logic [BYTE_W-1:0] CMD_PINS = 8'h00;
  localparam logic [BYTE_W-1:0] CMD_DRV  = 8'h01;
  localparam logic [BYTE_W-1:0] CMD_INV  = 8'h02;
  localparam logic [BYTE_W-1:0] CMD_DIR  = 8'h03;

  localparam logic [BYTE_W-1:0] RST_DRV = 8'hFF;
  localparam logic [BYTE_W-1:0] RST_INV = 8'h00;
  localparam logic [BYTE_W-1:0] RST_DIR = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_CMD, S_WDATA, S_ACK, S_RDATA, S_RACK, S_WAIT
  } bus_state_e;
endpackage

// File: rtl/pex_sync.sv
module pex_sync #(
  parameter int              W       = 1,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/pex_bus_fsm.sv
module pex_bus_fsm
  import pex_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR = 7'h24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] ptr_o,
  output logic              wr_en_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              sda_oe_o
);
  localparam int              CNT_W    = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  logic scl_q, sda_q;
  logic scl_rise, scl_fall, start_det, stop_det;

  bus_state_e        state_q, state_d, follow_q, follow_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d, ptr_q, ptr_d, wr_data_q, wr_data_d;
  logic              mack_q, mack_d, sda_oe_q, sda_oe_d, wr_en_q, wr_en_d;

  assign scl_rise  = scl_i & ~scl_q;
  assign scl_fall  = ~scl_i & scl_q;
  assign start_det = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_det  = scl_i & scl_q & ~sda_q & sda_i;

  always_comb begin
    state_d   = state_q;
    follow_d  = follow_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    ptr_d     = ptr_q;
    mack_d    = mack_q;
    sda_oe_d  = sda_oe_q;
    wr_en_d   = 1'b0;
    wr_data_d = wr_data_q;
    if (start_det) begin
      state_d  = S_ADDR;
      cnt_d    = '0;
      sda_oe_d = 1'b0;
    end else if (stop_det) begin
      state_d  = S_IDLE;
      sda_oe_d = 1'b0;
    end else begin
      unique case (state_q)
        S_ADDR, S_CMD, S_WDATA: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_i};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            sda_oe_d = 1'b1;
            state_d  = S_ACK;
            if (state_q == S_ADDR) begin
              if (sh_q[BYTE_W-1:1] == SLV_ADDR) begin
                follow_d = sh_q[0] ? S_RDATA : S_CMD;
              end else begin
                sda_oe_d = 1'b0;
                state_d  = S_WAIT;
              end
            end else if (state_q == S_CMD) begin
              ptr_d    = sh_q;
              follow_d = S_WDATA;
            end else begin
              wr_en_d   = 1'b1;
              wr_data_d = sh_q;
              follow_d  = S_WDATA;
            end
          end
        end
        S_ACK: begin
          if (scl_fall) begin
            cnt_d   = '0;
            state_d = follow_q;
            if (follow_q == S_RDATA) begin
              sh_d     = rd_data;
              sda_oe_d = ~rd_data[BYTE_W-1];
            end else begin
              sda_oe_d = 1'b0;
            end
          end
        end
        S_RDATA: begin
          if (scl_rise) begin
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall) begin
            if (cnt_q == CNT_FULL) begin
              sda_oe_d = 1'b0;
              state_d  = S_RACK;
            end else begin
              sh_d     = {sh_q[BYTE_W-2:0], 1'b0};
              sda_oe_d = ~sh_q[BYTE_W-2];
            end
          end
        end
        S_RACK: begin
          if (scl_rise) begin
            mack_d = ~sda_i;
          end else if (scl_fall) begin
            if (mack_q) begin
              sh_d     = rd_data;
              sda_oe_d = ~rd_data[BYTE_W-1];
              cnt_d    = '0;
              state_d  = S_RDATA;
            end else begin
              state_d  = S_WAIT;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      state_q   <= S_IDLE;
      follow_q  <= S_IDLE;
      cnt_q     <= '0;
      sh_q      <= '0;
      ptr_q     <= CMD_PINS;
      mack_q    <= 1'b0;
      sda_oe_q  <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      scl_q     <= scl_i;
      sda_q     <= sda_i;
      state_q   <= state_d;
      follow_q  <= follow_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      ptr_q     <= ptr_d;
      mack_q    <= mack_d;
      sda_oe_q  <= sda_oe_d;
      wr_en_q   <= wr_en_d;
      wr_data_q <= wr_data_d;
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = sda_oe_q;

  // R11: a STOP always lands in idle
  p_stop_to_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> state_q == S_IDLE);

  // R11: idle never holds SDA
  p_idle_released_r11: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_IDLE |-> !sda_oe_q);

  // R8: the pull-down only starts after SCL was seen low
  p_drive_on_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_q) |-> !$past(scl_i));

  // R2: an unaddressed or NACKed slave keeps SDA released
  p_wait_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == S_WAIT |-> !sda_oe_q);
endmodule

// File: rtl/pex_regs.sv
module pex_regs
  import pex_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] pins_s,
  output logic [BYTE_W-1:0] rd_data,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe_o
);
  logic [BYTE_W-1:0] drv_q, drv_d, inv_q, inv_d, dir_q, dir_d;
  logic [BYTE_W-1:0] pin_view;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_view
    assign pin_view[g] = inv_q[g] ? ~pins_s[g] : pins_s[g];
  end

  always_comb begin
    drv_d = drv_q;
    inv_d = inv_q;
    dir_d = dir_q;
    if (wr_en) begin
      case (ptr)
        CMD_DRV: drv_d = wr_data;
        CMD_INV: inv_d = wr_data;
        CMD_DIR: dir_d = wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_q <= RST_DRV;
      inv_q <= RST_INV;
      dir_q <= RST_DIR;
    end else begin
      drv_q <= drv_d;
      inv_q <= inv_d;
      dir_q <= dir_d;
    end
  end

  always_comb begin
    case (ptr)
      CMD_PINS: rd_data = pin_view;
      CMD_DRV:  rd_data = drv_q;
      CMD_INV:  rd_data = inv_q;
      CMD_DIR:  rd_data = dir_q;
      default:  rd_data = '0;
    endcase
  end

  assign pin_o    = drv_q;
  assign pin_oe_o = ~dir_q;

  // R7: writes to the pin view change nothing
  p_pins_readonly_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == CMD_PINS) |=> ($stable(drv_q) && $stable(inv_q) && $stable(dir_q)));

  // R10: writes above the last pointer change nothing
  p_high_ptr_inert_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr > CMD_DIR) |=> ($stable(drv_q) && $stable(inv_q) && $stable(dir_q)));

  // R5: a direction write sets the enables to its complement
  p_dir_to_oe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == CMD_DIR) |=> pin_oe_o == ~$past(wr_data));
endmodule

// File: rtl/i2c_port_expander.sv
module i2c_port_expander
  import pex_pkg::*;
#(
  parameter logic [6:0] SLV_ADDR    = 7'h24,
  parameter int         SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] pin_o,
  output logic [BYTE_W-1:0] pin_oe_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n;
  logic [1:0]        bus_s;
  logic [BYTE_W-1:0] pins_s, rd_data, ptr, wr_data;
  logic              wr_en;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) rst_pipe_q <= '0;
    else         rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n = rst_pipe_q[1];

  pex_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

  pex_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pins_s));

  pex_bus_fsm #(.SLV_ADDR(SLV_ADDR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_s[1]), .sda_i(bus_s[0]),
    .rd_data(rd_data), .ptr_o(ptr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .sda_oe_o(sda_oe_o));

  pex_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .ptr(ptr), .wr_data(wr_data),
    .pins_s(pins_s), .rd_data(rd_data), .pin_o(pin_o), .pin_oe_o(pin_oe_o));
endmodule

// File: tb/i2c_port_expander_tb.sv
`timescale 1ns/1ps
module i2c_port_expander_tb;
  localparam logic [6:0] DEV = 7'h24;
  localparam int Q = 8;

  typedef logic [7:0] bytes4_t [4];
  typedef struct { logic [7:0] v; string tag; } item_t;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_ni, scl_m, sda_m, sda_oe, sda_bus;
  logic [7:0] ext, pin_i, pin_o, pin_oe;
  logic [7:0] m_drv, m_inv, m_dir;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  item_t      exp_q [$];
  logic [7:0] act_q [$];

  assign sda_bus = sda_m & ~sda_oe;
  assign pin_i   = (pin_oe & pin_o) | (~pin_oe & ext);

  i2c_port_expander #(.SLV_ADDR(DEV), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_ni(rst_ni), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe_o(pin_oe));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; hq(); scl_m = 1'b1; hq(); sda_m = 1'b0; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hq(); scl_m = 1'b1; hq(); sda_m = 1'b1; hq();
  endtask

  task automatic bus_bit(input logic b, output logic r);
    sda_m = b; hq(); scl_m = 1'b1; hq(); r = sda_bus; hq(); scl_m = 1'b0; hq();
  endtask

  task automatic send_byte(input logic [7:0] v, output bit ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(v[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] v);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      v[i] = r;
    end
    bus_bit(~give_ack, r);
  endtask

  function automatic logic [7:0] model_val(input logic [7:0] cmd);
    case (cmd)
      8'h00:   return ((~m_dir & m_drv) | (m_dir & ext)) ^ m_inv;
      8'h01:   return m_drv;
      8'h02:   return m_inv;
      8'h03:   return m_dir;
      default: return 8'h00;
    endcase
  endfunction

  task automatic wr_reg(input logic [7:0] cmd, input bytes4_t d, input int n, input string req);
    bit ack;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2", "address ack", {7'h0, ack}, 8'h01);
    send_byte(cmd, ack);         chk(ack, "R3", "command ack", {7'h0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      send_byte(d[i], ack);
      chk(ack, req, "data ack", {7'h0, ack}, 8'h01);
    end
    bus_stop();
    if (n > 0) begin
      case (cmd)
        8'h01: m_drv = d[n-1];
        8'h02: m_inv = d[n-1];
        8'h03: m_dir = d[n-1];
        default: ;
      endcase
    end
  endtask

  task automatic rd_reg(input logic [7:0] cmd, input int n, input string req);
    bit ack;
    logic [7:0] v;
    bus_start();
    send_byte({DEV, 1'b0}, ack); chk(ack, "R2", "address ack", {7'h0, ack}, 8'h01);
    send_byte(cmd, ack);         chk(ack, "R3", "command ack", {7'h0, ack}, 8'h01);
    bus_start();
    send_byte({DEV, 1'b1}, ack); chk(ack, "R9", "read address ack", {7'h0, ack}, 8'h01);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back('{v: model_val(cmd), tag: req});
      recv_byte(i != n - 1, v);
      act_q.push_back(v);
    end
    bus_stop();
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] a;
        item_t e;
        a = act_q.pop_front();
        e = exp_q.pop_front();
        chk(a == e.v, e.tag, "read byte", a, e.v);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R11 watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] v;
    scl_m = 1'b1; sda_m = 1'b1; ext = 8'h00; rst_ni = 1'b0;
    m_drv = 8'hFF; m_inv = 8'h00; m_dir = 8'hFF;
    repeat (5) @(negedge clk);
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state at the pins and through reads
    chk(pin_oe == 8'h00, "R1", "reset enables", pin_oe, 8'h00);
    chk(pin_o == 8'hFF, "R1", "reset drive", pin_o, 8'hFF);
    rd_reg(8'h01, 1, "R1");
    rd_reg(8'h02, 1, "R1");
    rd_reg(8'h03, 1, "R1");
    rd_reg(8'h00, 1, "R6");

    // R4 R5 direction and drive
    wr_reg(8'h03, '{8'hF0, 8'h00, 8'h00, 8'h00}, 1, "R4");
    wr_reg(8'h01, '{8'hA5, 8'h00, 8'h00, 8'h00}, 1, "R4");
    chk(pin_oe == 8'h0F, "R5", "enables", pin_oe, 8'h0F);
    chk(pin_o == 8'hA5, "R5", "drive", pin_o, 8'hA5);

    // R6 pin view mixes driven and external levels, then inversion
    ext = 8'h3C;
    rd_reg(8'h00, 1, "R6");
    wr_reg(8'h02, '{8'h81, 8'h00, 8'h00, 8'h00}, 1, "R4");
    rd_reg(8'h00, 1, "R6");
    rd_reg(8'h02, 1, "R4");
    chk(pin_o == 8'hA5, "R5", "drive not inverted", pin_o, 8'hA5);

    // R7 write to pin view ignored
    wr_reg(8'h00, '{8'h00, 8'h00, 8'h00, 8'h00}, 1, "R7");
    chk(pin_o == 8'hA5, "R7", "drive after pin-view write", pin_o, 8'hA5);
    chk(pin_oe == 8'h0F, "R7", "enables after pin-view write", pin_oe, 8'h0F);
    rd_reg(8'h02, 1, "R7");

    // R9 no auto-increment; R8 multi-byte read with ACK
    wr_reg(8'h01, '{8'h11, 8'h22, 8'h00, 8'h00}, 2, "R9");
    rd_reg(8'h02, 1, "R9");
    rd_reg(8'h01, 3, "R8");
    chk(pin_o == 8'h22, "R9", "last byte kept", pin_o, 8'h22);

    // R2 address mismatch
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, ack);
    chk(!ack, "R2", "foreign address nack", {7'h0, ack}, 8'h00);
    send_byte(8'h01, ack);
    send_byte(8'h00, ack);
    bus_stop();
    chk(pin_o == 8'h22, "R2", "ignored transaction", pin_o, 8'h22);

    // R10 pointer above range
    wr_reg(8'h07, '{8'h55, 8'h00, 8'h00, 8'h00}, 1, "R10");
    rd_reg(8'h07, 1, "R10");
    rd_reg(8'h03, 1, "R10");
    chk(pin_o == 8'h22, "R10", "drive unchanged", pin_o, 8'h22);

    // R11 STOP then new read reusing the stored pointer; R8 release after NACK
    bus_start();
    send_byte({DEV, 1'b0}, ack);
    send_byte(8'h03, ack);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, ack);
    chk(ack, "R11", "fresh read address ack", {7'h0, ack}, 8'h01);
    exp_q.push_back('{v: model_val(8'h03), tag: "R11"});
    recv_byte(1'b0, v);
    act_q.push_back(v);
    hq();
    chk(sda_oe == 1'b0, "R8", "released after nack", {7'h0, sda_oe}, 8'h00);
    bus_stop();
    hq();
    chk(sda_oe == 1'b0, "R11", "idle after stop", {7'h0, sda_oe}, 8'h00);

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R8", "scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule